// File: doc/BRIEF.md
# Dataflow Task Firing Wrapper

This block surrounds one coarse-grained hardware task core and runs it under synchronous-dataflow firing rules. The core's input and output edge buffers all live in one single-port local memory. Every edge has a build-time rate: the number of tokens it consumes or produces in each firing. Every edge also has a base address. The first input edge has a build-time total token count, and that total fixes how many firings one run makes.

A single-cycle start command begins a run, which cannot be interrupted. Each firing has three phases:

- It fetches the input tokens one at a time over the memory port, edge by edge, into an internal buffer.
- It launches the core with the full input set present and waits for the core's completion strobe.
- It captures the core's results and stores them back through the same port, edge by edge.

After each firing every edge pointer advances by that edge's rate. After the last firing a one-cycle finish pulse is raised.

The controller is a state machine with these states:

- IDLE waits for start. It goes to READ, or straight to FINISH when the firing count is zero.
- READ holds a read request until it is granted, then goes to RDATA.
- RDATA captures the returned word. It goes back to READ for the next token, or to LAUNCH after the last token of the last input edge.
- LAUNCH pulses the core start for one cycle and goes to EXEC.
- EXEC waits for the core's done strobe, then goes to WRITE.
- WRITE holds a write request until it is granted. After the last granted token of the last output edge it goes to ADV.
- ADV steps all edge pointers. It goes back to READ, or to FINISH after the last firing.
- FINISH raises the finish pulse and returns to IDLE.

Top module: `sdfw_wrapper`

## Requirements
- R1: After reset the wrapper is idle: busy, finish, core_go and mem_req are all 0, and while idle none of them is raised.
- R2: A start seen while idle sets busy from the next cycle. A start seen while busy is ignored: the run makes no extra firing and gives no extra finish.
- R3: A run makes exactly FIRST_IN_TOTAL / (rate of input edge 0) firings. With the defaults (input rates 4 and 2, first total 100) that is 25 firings. The core is launched once per firing.
- R4: In each firing the input edges are read in ascending edge index. Edge e issues exactly rate(e) reads at consecutive addresses starting at its pointer. The pointer starts at the edge's base address and grows by rate(e) after each firing.
- R5: When core_go pulses, every input token of the firing is present on core_in_tokens. The slots are packed edge 0 first, and within an edge in address order, with slot s at bits [s*DW +: DW]. No memory request is made between core_go and core_done.
- R6: core_go is a one-cycle pulse. core_done is taken only after the launch, and the done strobe captures core_out_tokens.
- R7: Output tokens are written in ascending edge index and in ascending slot order. Slot 0 goes to output edge 0, and the following slots go to the later edges. Edge e issues rate(e) writes at consecutive addresses from its pointer, which starts at its base and grows by rate(e) per firing.
- R8: mem_req stays high, with mem_addr, mem_we and mem_wdata unchanged, until mem_gnt is seen. Read data is taken from mem_rdata in the cycle after the grant.
- R9: After the last write of the last firing, finish is high for exactly one cycle, and busy is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only while idle) |
| busy | output | 1 | Run in progress |
| finish | output | 1 | One-cycle end-of-run pulse |
| core_go | output | 1 | One-cycle launch of the task core |
| core_in_tokens | output | IN_SUM*DW | All input tokens of the current firing |
| core_done | input | 1 | Core completion strobe |
| core_out_tokens | input | OUT_SUM*DW | Core results, captured on core_done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Grant for the pending request |
| mem_rdata | input | DW | Read data, valid the cycle after a read grant |

## Verification
The two events that can meet in one cycle are a new start command and a run that is already in flight. The bench raises start again just after the tenth core launch, while the core is computing or the next fetch is under way. The run must still end with exactly 25 launches, one finish pulse and an unchanged sequence of memory addresses. A second overlap is between a withheld grant and an edge or phase boundary. Under random grant, the bench checks that each granted address still follows the per-edge order and that every written word matches the value computed from the original memory contents.

// File: rtl/sdfw_pkg.sv
package sdfw_pkg;

    localparam int RATE_W      = 8;
    localparam int FIELD_VEC_W = 256;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RDATA,
        ST_LAUNCH,
        ST_EXEC,
        ST_WRITE,
        ST_ADV,
        ST_FINISH
    } sdfw_state_e;

    // Sum of n packed RATE_W-wide fields, field 0 in the low bits.
    function automatic int field_sum(input logic [FIELD_VEC_W-1:0] v, input int n);
        int acc;
        acc = 0;
        for (int i = 0; i < n; i++) begin
            acc += int'(v[i*RATE_W +: RATE_W]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/sdfw_ptr_bank.sv
module sdfw_ptr_bank #(
    parameter int N  = 2,
    parameter int AW = 12,
    parameter int RW = 8,
    parameter logic [N*RW-1:0] RATES = '0,
    parameter logic [N*AW-1:0] BASES = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [N*AW-1:0] ptrs
);

    for (genvar e = 0; e < N; e++) begin : g_edge
        logic [AW-1:0] ptr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q <= BASES[e*AW +: AW];
            end else if (load) begin
                ptr_q <= BASES[e*AW +: AW];
            end else if (step) begin
                ptr_q <= ptr_q + AW'(RATES[e*RW +: RW]);
            end
        end

        assign ptrs[e*AW +: AW] = ptr_q;
    end

endmodule

// File: rtl/sdfw_in_buf.sv
module sdfw_in_buf #(
    parameter int DW    = 16,
    parameter int SLOTS = 6,
    parameter int SW    = 3,
    parameter bit SHIFT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_slot,
    input  logic [DW-1:0]       wr_data,
    output logic [SLOTS*DW-1:0] tokens
);

    logic [SLOTS*DW-1:0] store_q;

    if (SHIFT && SLOTS > 1) begin : g_shift
        // New word enters at the top; after SLOTS writes the first word sits in slot 0.
        logic unused_slot;
        assign unused_slot = ^wr_slot;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q <= '0;
            end else if (wr_en) begin
                store_q <= {wr_data, store_q[SLOTS*DW-1:DW]};
            end
        end
    end else begin : g_indexed
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q <= '0;
            end else if (wr_en) begin
                store_q[int'(wr_slot)*DW +: DW] <= wr_data;
            end
        end
    end

    assign tokens = store_q;

endmodule

// File: rtl/sdfw_out_buf.sv
module sdfw_out_buf #(
    parameter int DW    = 16,
    parameter int SLOTS = 4,
    parameter int SW    = 3,
    parameter bit SHIFT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SLOTS*DW-1:0] load_bus,
    input  logic                adv,
    input  logic [SW-1:0]       rd_slot,
    output logic [DW-1:0]       rd_data
);

    logic [SLOTS*DW-1:0] store_q;

    if (SHIFT && SLOTS > 1) begin : g_shift
        logic unused_slot;
        assign unused_slot = ^rd_slot;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q <= '0;
            end else if (load) begin
                store_q <= load_bus;
            end else if (adv) begin
                store_q <= store_q >> DW;
            end
        end

        assign rd_data = store_q[DW-1:0];
    end else begin : g_indexed
        logic unused_adv;
        assign unused_adv = adv;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q <= '0;
            end else if (load) begin
                store_q <= load_bus;
            end
        end

        assign rd_data = store_q[int'(rd_slot)*DW +: DW];
    end

endmodule

// File: rtl/sdfw_wrapper.sv
module sdfw_wrapper
    import sdfw_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 12,
    parameter int N_IN   = 2,
    parameter int N_OUT  = 2,
    parameter logic [N_IN*RATE_W-1:0]  IN_RATES  = {8'd2, 8'd4},
    parameter logic [N_OUT*RATE_W-1:0] OUT_RATES = {8'd3, 8'd1},
    parameter logic [N_IN*AW-1:0]      IN_BASES  = {12'h100, 12'h000},
    parameter logic [N_OUT*AW-1:0]     OUT_BASES = {12'h300, 12'h200},
    parameter int FIRST_IN_TOTAL = 100,
    parameter bit BUF_SHIFT      = 1'b0,
    localparam int IN_SUM  = field_sum(FIELD_VEC_W'(IN_RATES), N_IN),
    localparam int OUT_SUM = field_sum(FIELD_VEC_W'(OUT_RATES), N_OUT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  busy,
    output logic                  finish,
    output logic                  core_go,
    output logic [IN_SUM*DW-1:0]  core_in_tokens,
    input  logic                  core_done,
    input  logic [OUT_SUM*DW-1:0] core_out_tokens,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_wdata,
    input  logic                  mem_gnt,
    input  logic [DW-1:0]         mem_rdata
);

    localparam int FIRINGS  = FIRST_IN_TOTAL / int'(IN_RATES[RATE_W-1:0]);
    localparam int N_MAX    = (N_IN > N_OUT) ? N_IN : N_OUT;
    localparam int EW       = (N_MAX > 1) ? $clog2(N_MAX) : 1;
    localparam int SUM_MAX  = (IN_SUM > OUT_SUM) ? IN_SUM : OUT_SUM;
    localparam int SW       = $clog2(SUM_MAX + 1);
    localparam int FW       = (FIRINGS > 1) ? $clog2(FIRINGS) : 1;

    sdfw_state_e state_q, state_d;

    logic [EW-1:0]     edge_q;
    logic [RATE_W-1:0] tok_q;
    logic [SW-1:0]     slot_q;
    logic [FW-1:0]     fire_q;

    logic [N_IN*AW-1:0]  in_ptrs;
    logic [N_OUT*AW-1:0] out_ptrs;
    logic [RATE_W-1:0]   cur_in_rate, cur_out_rate;
    logic [AW-1:0]       cur_in_ptr, cur_out_ptr;
    logic                in_tok_last, in_edge_last, out_tok_last, out_edge_last;
    logic                ptr_load, ptr_step, ibuf_we, obuf_load, obuf_adv;
    logic [DW-1:0]       obuf_data;

    // Per-edge lookups
    assign cur_in_rate   = IN_RATES[int'(edge_q)*RATE_W +: RATE_W];
    assign cur_out_rate  = OUT_RATES[int'(edge_q)*RATE_W +: RATE_W];
    assign cur_in_ptr    = in_ptrs[int'(edge_q)*AW +: AW];
    assign cur_out_ptr   = out_ptrs[int'(edge_q)*AW +: AW];
    assign in_tok_last   = (tok_q == cur_in_rate - 1'b1);
    assign out_tok_last  = (tok_q == cur_out_rate - 1'b1);
    assign in_edge_last  = (edge_q == EW'(N_IN - 1));
    assign out_edge_last = (edge_q == EW'(N_OUT - 1));

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            edge_q  <= '0;
            tok_q   <= '0;
            slot_q  <= '0;
            fire_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        edge_q <= '0;
                        tok_q  <= '0;
                        slot_q <= '0;
                        fire_q <= '0;
                    end
                end
                ST_RDATA: begin
                    slot_q <= slot_q + SW'(1);
                    if (in_tok_last) begin
                        tok_q <= '0;
                        if (in_edge_last) begin
                            edge_q <= '0;
                            slot_q <= '0;
                        end else begin
                            edge_q <= edge_q + EW'(1);
                        end
                    end else begin
                        tok_q <= tok_q + RATE_W'(1);
                    end
                end
                ST_WRITE: begin
                    if (mem_gnt) begin
                        slot_q <= slot_q + SW'(1);
                        if (out_tok_last) begin
                            tok_q <= '0;
                            if (out_edge_last) begin
                                edge_q <= '0;
                                slot_q <= '0;
                            end else begin
                                edge_q <= edge_q + EW'(1);
                            end
                        end else begin
                            tok_q <= tok_q + RATE_W'(1);
                        end
                    end
                end
                ST_ADV: begin
                    fire_q <= fire_q + FW'(1);
                end
                default: ;
            endcase
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (FIRINGS == 0) ? ST_FINISH : ST_READ;
            ST_READ:   if (mem_gnt) state_d = ST_RDATA;
            ST_RDATA:  state_d = (in_tok_last && in_edge_last) ? ST_LAUNCH : ST_READ;
            ST_LAUNCH: state_d = ST_EXEC;
            ST_EXEC:   if (core_done) state_d = ST_WRITE;
            ST_WRITE:  if (mem_gnt && out_tok_last && out_edge_last) state_d = ST_ADV;
            ST_ADV:    state_d = (fire_q == FW'(FIRINGS - 1)) ? ST_FINISH : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        busy      = 1'b1;
        finish    = 1'b0;
        core_go   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ptr_load  = 1'b0;
        ptr_step  = 1'b0;
        ibuf_we   = 1'b0;
        obuf_load = 1'b0;
        obuf_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                ptr_load = start;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = cur_in_ptr + AW'(tok_q);
            end
            ST_RDATA:  ibuf_we = 1'b1;
            ST_LAUNCH: core_go = 1'b1;
            ST_EXEC:   obuf_load = core_done;
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_out_ptr + AW'(tok_q);
                mem_wdata = obuf_data;
                obuf_adv  = mem_gnt;
            end
            ST_ADV:    ptr_step = 1'b1;
            ST_FINISH: finish = 1'b1;
            default: ;
        endcase
    end

    sdfw_ptr_bank #(
        .N(N_IN), .AW(AW), .RW(RATE_W), .RATES(IN_RATES), .BASES(IN_BASES)
    ) u_in_ptrs (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .step(ptr_step), .ptrs(in_ptrs)
    );

    sdfw_ptr_bank #(
        .N(N_OUT), .AW(AW), .RW(RATE_W), .RATES(OUT_RATES), .BASES(OUT_BASES)
    ) u_out_ptrs (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .step(ptr_step), .ptrs(out_ptrs)
    );

    sdfw_in_buf #(
        .DW(DW), .SLOTS(IN_SUM), .SW(SW), .SHIFT(BUF_SHIFT)
    ) u_in_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(ibuf_we), .wr_slot(slot_q),
        .wr_data(mem_rdata), .tokens(core_in_tokens)
    );

    sdfw_out_buf #(
        .DW(DW), .SLOTS(OUT_SUM), .SW(SW), .SHIFT(BUF_SHIFT)
    ) u_out_buf (
        .clk(clk), .rst_n(rst_n), .load(obuf_load), .load_bus(core_out_tokens),
        .adv(obuf_adv), .rd_slot(slot_q), .rd_data(obuf_data)
    );

endmodule

// File: rtl/sdfw_checker.sv
module sdfw_checker #(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          finish,
    input logic          core_go,
    input logic          core_done,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_gnt
);

    // High from a launch until the core reports completion.
    logic exec_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         exec_q <= 1'b0;
        else if (core_go)   exec_q <= 1'b1;
        else if (core_done) exec_q <= 1'b0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !core_go && !finish));

    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_no_mem_in_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |-> !mem_req);

    p_go_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_go |=> !core_go);

    p_hold_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_finish_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish);

    p_finish_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy);

endmodule

bind sdfw_wrapper sdfw_checker #(.DW(DW), .AW(AW)) u_sdfw_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .finish(finish),
    .core_go(core_go), .core_done(core_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
);

// File: tb/sdfw_wrapper_tb_top.sv
module sdfw_wrapper_tb_top;

    localparam int DW = 16;
    localparam int AW = 12;
    localparam logic [AW-1:0] IN0_B  = 12'h000;
    localparam logic [AW-1:0] IN1_B  = 12'h100;
    localparam logic [AW-1:0] OUT0_B = 12'h200;
    localparam logic [AW-1:0] OUT1_B = 12'h300;
    localparam int NFIRE = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic core_done = 1'b0;
    logic mem_gnt = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [4*DW-1:0] core_out_tokens = '0;
    logic busy, finish, core_go, mem_req, mem_we;
    logic [6*DW-1:0] core_in_tokens;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] mem [0:4095];
    logic [DW-1:0] init0 [0:99];
    logic [DW-1:0] init1 [0:49];

    int checks = 0, errors = 0;
    int rd_idx = 0, wr_idx = 0, go_n = 0, fin_n = 0;
    int rd_bad = 0, wr_bad = 0, exec_bad = 0, core_cnt = 0, gnt_mode = 0;

    always #4 clk = ~clk;

    sdfw_wrapper #(
        .DW(DW), .AW(AW), .N_IN(2), .N_OUT(2),
        .IN_RATES({8'd2, 8'd4}), .OUT_RATES({8'd3, 8'd1}),
        .IN_BASES({IN1_B, IN0_B}), .OUT_BASES({OUT1_B, OUT0_B}),
        .FIRST_IN_TOTAL(100), .BUF_SHIFT(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .finish(finish),
        .core_go(core_go), .core_in_tokens(core_in_tokens), .core_done(core_done),
        .core_out_tokens(core_out_tokens), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_sum(input int f);
        logic [DW-1:0] s;
        s = '0;
        for (int k = 0; k < 4; k++) s = s + init0[4*f+k];
        for (int k = 0; k < 2; k++) s = s + init1[2*f+k];
        return s;
    endfunction

    function automatic logic [AW-1:0] exp_rd_addr(input int i);
        int f, r;
        f = i / 6;
        r = i % 6;
        if (r < 4) return IN0_B + AW'(4*f + r);
        return IN1_B + AW'(2*f + r - 4);
    endfunction

    function automatic logic [AW-1:0] exp_wr_addr(input int i);
        int f, r;
        f = i / 4;
        r = i % 4;
        if (r == 0) return OUT0_B + AW'(f);
        return OUT1_B + AW'(3*f + r - 1);
    endfunction

    // Core model, memory model and event counters, all at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            core_done = 1'b0;
            if (finish) fin_n++;
            if (core_cnt > 0 && mem_req) exec_bad++;
            if (core_cnt > 0) begin
                core_cnt--;
                if (core_cnt == 0) core_done = 1'b1;
            end
            if (core_go) begin
                int f;
                logic [6*DW-1:0] expv;
                logic [DW-1:0] s;
                f = go_n;
                go_n++;
                if (f < NFIRE) begin
                    for (int k = 0; k < 6; k++)
                        expv[k*DW +: DW] = (k < 4) ? init0[4*f+k] : init1[2*f+k-4];
                    // R5: whole input set present at launch, edge 0 in low slots
                    chk(core_in_tokens == expv, "R5", "input tokens at launch",
                        int'(core_in_tokens[DW-1:0]), int'(expv[DW-1:0]));
                end
                s = '0;
                for (int k = 0; k < 6; k++) s = s + core_in_tokens[k*DW +: DW];
                for (int k = 0; k < 4; k++) core_out_tokens[k*DW +: DW] = s + DW'(k * 16'h0101);
                core_cnt = 1 + int'($urandom % 4);
            end
            mem_gnt = (gnt_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    int f, r;
                    f = wr_idx / 4;
                    r = wr_idx % 4;
                    if (f >= NFIRE || mem_addr != exp_wr_addr(wr_idx) ||
                        mem_wdata != exp_sum(f) + DW'(r * 16'h0101)) wr_bad++;
                    mem[mem_addr] = mem_wdata;
                    wr_idx++;
                end else begin
                    if (rd_idx >= 6*NFIRE || mem_addr != exp_rd_addr(rd_idx)) rd_bad++;
                    mem_rdata = mem[mem_addr];
                    rd_idx++;
                end
            end
        end
    end

    task automatic run_task(input int mode, input bit poke, input string name);
        bit poked;
        int out_bad;
        for (int i = 0; i < 100; i++) begin
            init0[i] = DW'($urandom);
            mem[IN0_B + AW'(i)] = init0[i];
        end
        for (int i = 0; i < 50; i++) begin
            init1[i] = DW'($urandom);
            mem[IN1_B + AW'(i)] = init1[i];
        end
        for (int i = 0; i < 25; i++) mem[OUT0_B + AW'(i)] = '0;
        for (int i = 0; i < 75; i++) mem[OUT1_B + AW'(i)] = '0;
        gnt_mode = mode;
        rd_idx = 0; wr_idx = 0; go_n = 0; fin_n = 0;
        rd_bad = 0; wr_bad = 0; exec_bad = 0;

        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);

        poked = 1'b0;
        while (fin_n == 0) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && !poked && go_n >= 10) begin
                start = 1'b1;     // R2: start while busy must be ignored
                poked = 1'b1;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9", {name, " idle after finish"}, int'(busy), 0);
        repeat (6) @(negedge clk);

        chk(fin_n == 1, "R9", {name, " finish pulses"}, fin_n, 1);
        chk(go_n == NFIRE, "R3", {name, " firings"}, go_n, NFIRE);
        chk(rd_idx == 150, "R4", {name, " read count"}, rd_idx, 150);
        chk(rd_bad == 0, "R4", {name, " read address order"}, rd_bad, 0);
        chk(wr_idx == 100, "R7", {name, " write count"}, wr_idx, 100);
        chk(wr_bad == 0, "R7", {name, " write address/data order"}, wr_bad, 0);
        chk(exec_bad == 0, "R5", {name, " memory quiet while core runs"}, exec_bad, 0);

        out_bad = 0;
        for (int f = 0; f < NFIRE; f++) begin
            if (mem[OUT0_B + AW'(f)] != exp_sum(f)) out_bad++;
            for (int j = 0; j < 3; j++)
                if (mem[OUT1_B + AW'(3*f + j)] != exp_sum(f) + DW'((j + 1) * 16'h0101)) out_bad++;
        end
        // R6 and R8: results captured on done, read data taken after the grant
        chk(out_bad == 0, "R6", {name, " output region contents"}, out_bad, 0);
        chk(out_bad == 0 && rd_bad == 0, "R8", {name, " handshake data integrity"}, out_bad + rd_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && finish == 1'b0, "R1", "reset busy/finish", int'({busy, finish}), 0);
        chk(core_go == 1'b0 && mem_req == 1'b0, "R1", "reset go/req", int'({core_go, mem_req}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", int'({busy, mem_req}), 0);

        run_task(0, 1'b0, "full-grant");
        run_task(1, 1'b1, "random-grant+restart");
        run_task(1, 1'b0, "random-grant");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule